// File: doc/BRIEF.md
# E1 Receive Alarm Detector

This block sits behind the frame and multiframe aligners of an E1 receiver and turns received alarm fields and raw line samples into real-time alarm levels. Two strobed inputs carry alarm bits pulled from the frame. One carries the remote alarm indication bit of each non-align frame. The other carries the distant multiframe alarm bit, which the aligner extracts from the signalling time slot of multiframe frame 0. Each alarm enters or leaves its state only after a configurable number of consecutive matching occurrences, three by default.

A third path watches the positive and negative rail samples on every receive clock. It raises carrier loss after a long run of periods with both rails at zero, and drops it on the first mark. Three status latches hold the remote alarm, the distant multiframe alarm and the synchronizer's loss-of-sync level. Each latch sets while its live signal is high and clears when a one is written to its clear bit.

Top module: `e1_rx_alarm`

## Requirements
- R1: With the remote alarm low, `remote_alarm` goes high in the cycle after the CONSEC_RAI-th (3) consecutive `rai_vld` strobe that carries `rai_bit`=1.
- R2: With the remote alarm high, `remote_alarm` goes low in the cycle after the third consecutive strobe that carries `rai_bit`=0.
- R3: A strobe whose value equals the current alarm state restarts the consecutive count, so the sequence 1,1,0,1,1 leaves a low alarm low.
- R4: `mf_alarm` follows the same three-occurrence rule on `mfa_vld`/`mfa_bit`, and it is independent of the remote-alarm path.
- R5: `carrier_loss` goes high in the cycle after the RUN_LEN-th (32) consecutive clock with `pos_rail`=0 and `neg_rail`=0. It stays low before that.
- R6: A one on either rail drops `carrier_loss` in the next cycle and restarts the zero run, so 31 zeros, a one and then 31 more zeros leave it low.
- R7: The zero-run counter saturates and does not wrap. `carrier_loss` stays high through an outage of any length, for example 300 clocks.
- R8: Status bit `stat[0]` (remote), `stat[1]` (multiframe) and `stat[2]` (loss of sync) each go high in the cycle after their live signal is high. Each holds until a one is written to the matching bit of `stat_clr`.
- R9: Writing the clear bit while the live signal is still high leaves the status bit high.
- R10: After reset, all alarms and status bits are low and all run counters are zero.
- R11: Cycles with the strobe low do not change an alarm, whatever its data bit carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rai_vld | input | 1 | Strobe: remote alarm bit of a non-align frame is valid |
| rai_bit | input | 1 | Remote alarm indication bit |
| mfa_vld | input | 1 | Strobe: multiframe alarm bit of frame 0 is valid |
| mfa_bit | input | 1 | Distant multiframe alarm bit |
| pos_rail | input | 1 | Positive rail sample |
| neg_rail | input | 1 | Negative rail sample |
| sync_loss | input | 1 | Synchronizer loss-of-sync level |
| stat_clr | input | 3 | Write-one-to-clear for status bits {sync, mf, remote} |
| remote_alarm | output | 1 | Live remote alarm |
| mf_alarm | output | 1 | Live distant multiframe alarm |
| carrier_loss | output | 1 | Live carrier loss |
| stat | output | 3 | Latched status {sync, mf, remote} |

## Verification
Every result is due one clock after the edge that samples its cause. An alarm output moves one clock after the deciding strobe. Carrier loss moves one clock after the 32nd zero or after the first mark. A status bit follows its live signal one clock later, so a status bit that mirrors an alarm trails the strobe by two clocks. The bench drives inputs on the falling edge and samples just after the next rising edge. Status checks wait one further clock. The strobe sweeps cover all 64 six-strobe patterns on each alarm path, with an idle cycle carrying the opposite data value after every strobe.

// File: rtl/e1_alarm_pkg.sv
package e1_alarm_pkg;
   // Index of each latched status bit
   typedef enum int {
      STAT_REMOTE = 0,
      STAT_MFRAME = 1,
      STAT_SYNC   = 2
   } stat_idx_e;

   localparam int NUM_STAT  = 3;
   localparam int NUM_ALARM = 2;

   function automatic int cnt_width(input int limit);
      return (limit > 1) ? $clog2(limit + 1) : 1;
   endfunction
endpackage

// File: rtl/e1_consec_filter.sv
module e1_consec_filter #(
   parameter int CONSEC = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic occ_vld,
   input  logic occ_bit,
   output logic state
);
   localparam int CW = e1_alarm_pkg::cnt_width(CONSEC);

   if (CONSEC < 1) begin : g_bad_consec
      $error("e1_consec_filter: CONSEC must be at least 1");
   end

   if (CONSEC == 1) begin : g_direct
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       state <= 1'b0;
         else if (occ_vld) state <= occ_bit;
      end
   end else begin : g_counted
      logic [CW-1:0] run_cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            state   <= 1'b0;
            run_cnt <= '0;
         end else if (occ_vld) begin
            if (occ_bit == state) begin
               run_cnt <= '0;
            end else if (run_cnt == CW'(CONSEC - 1)) begin
               state   <= occ_bit;
               run_cnt <= '0;
            end else begin
               run_cnt <= run_cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/e1_zero_run.sv
module e1_zero_run #(
   parameter int RUN_LEN = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pos_in,
   input  logic neg_in,
   output logic loss
);
   localparam int CW = e1_alarm_pkg::cnt_width(RUN_LEN);

   if (RUN_LEN < 2) begin : g_bad_run
      $error("e1_zero_run: RUN_LEN must be at least 2");
   end

   logic [CW-1:0] zero_cnt;
   logic          mark;

   assign mark = pos_in | neg_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         zero_cnt <= '0;
         loss     <= 1'b0;
      end else if (mark) begin
         zero_cnt <= '0;
         loss     <= 1'b0;
      end else if (zero_cnt != CW'(RUN_LEN)) begin
         zero_cnt <= zero_cnt + 1'b1;
         if (zero_cnt == CW'(RUN_LEN - 1)) loss <= 1'b1;
      end
   end
endmodule

// File: rtl/e1_stat_latch.sv
module e1_stat_latch #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] live,
   input  logic [N-1:0] clr,
   output logic [N-1:0] stat
);
   if (N < 1) begin : g_bad_n
      $error("e1_stat_latch: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stat[i] <= 1'b0;
         else        stat[i] <= (stat[i] & ~clr[i]) | live[i];
      end
   end
endmodule

// File: rtl/e1_rx_alarm.sv
module e1_rx_alarm #(
   parameter int CONSEC_RAI = 3,
   parameter int CONSEC_MFA = 3,
   parameter int RUN_LEN    = 32
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rai_vld,
   input  logic       rai_bit,
   input  logic       mfa_vld,
   input  logic       mfa_bit,
   input  logic       pos_rail,
   input  logic       neg_rail,
   input  logic       sync_loss,
   input  logic [2:0] stat_clr,
   output logic       remote_alarm,
   output logic       mf_alarm,
   output logic       carrier_loss,
   output logic [2:0] stat
);
   import e1_alarm_pkg::*;

   logic [NUM_ALARM-1:0] a_vld, a_bit, a_state;
   logic [NUM_STAT-1:0]  live;

   assign a_vld = {mfa_vld, rai_vld};
   assign a_bit = {mfa_bit, rai_bit};

   for (genvar i = 0; i < NUM_ALARM; i++) begin : g_alarm
      localparam int CN = (i == 0) ? CONSEC_RAI : CONSEC_MFA;
      e1_consec_filter #(.CONSEC(CN)) u_filt (
         .clk     (clk),
         .rst_n   (rst_n),
         .occ_vld (a_vld[i]),
         .occ_bit (a_bit[i]),
         .state   (a_state[i])
      );
   end

   assign remote_alarm = a_state[0];
   assign mf_alarm     = a_state[1];

   e1_zero_run #(.RUN_LEN(RUN_LEN)) u_zrun (
      .clk    (clk),
      .rst_n  (rst_n),
      .pos_in (pos_rail),
      .neg_in (neg_rail),
      .loss   (carrier_loss)
   );

   always_comb begin
      live              = '0;
      live[STAT_REMOTE] = remote_alarm;
      live[STAT_MFRAME] = mf_alarm;
      live[STAT_SYNC]   = sync_loss;
   end

   e1_stat_latch #(.N(NUM_STAT)) u_stat (
      .clk   (clk),
      .rst_n (rst_n),
      .live  (live),
      .clr   (stat_clr),
      .stat  (stat)
   );
endmodule

// File: rtl/e1_rx_alarm_chk.sv
module e1_rx_alarm_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       rai_vld,
   input logic       rai_bit,
   input logic       mfa_vld,
   input logic       mfa_bit,
   input logic       pos_rail,
   input logic       neg_rail,
   input logic       sync_loss,
   input logic [2:0] stat_clr,
   input logic       remote_alarm,
   input logic       mf_alarm,
   input logic       carrier_loss,
   input logic [2:0] stat
);
   // R11
   rai_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rai_vld |=> $stable(remote_alarm));
   // R11
   mfa_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mfa_vld |=> $stable(mf_alarm));
   // R1
   rai_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(remote_alarm) |-> $past(rai_vld && rai_bit));
   // R2
   rai_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(remote_alarm) |-> $past(rai_vld && !rai_bit));
   // R6
   mark_clears_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pos_rail || neg_rail) |=> !carrier_loss);
   // R5
   loss_rise_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(carrier_loss) |-> $past(!pos_rail && !neg_rail));
   // R8
   stat_remote_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      remote_alarm |=> stat[0]);
   // R8
   stat_sync_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sync_loss |=> stat[2]);
   // R8
   stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat[1] && !stat_clr[1]) |=> stat[1]);
   // R9
   stat_clr_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_clr[2] && sync_loss) |=> stat[2]);
endmodule

bind e1_rx_alarm e1_rx_alarm_chk u_chk (.*);

// File: tb/e1_rx_alarm_bench.sv
module e1_rx_alarm_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rai_vld = 1'b0, rai_bit = 1'b0, mfa_vld = 1'b0, mfa_bit = 1'b0;
   logic       pos_rail = 1'b0, neg_rail = 1'b0, sync_loss = 1'b0;
   logic [2:0] stat_clr = '0;
   logic       remote_alarm, mf_alarm, carrier_loss;
   logic [2:0] stat;
   int         total = 0;
   int         bad = 0;
   bit         done = 0;

   localparam int RUN = 32;

   always #10 clk = ~clk;

   e1_rx_alarm u_e1_rx_alarm (.*);

   task automatic check(input string req, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; rai_vld = 0; mfa_vld = 0; pos_rail = 1; neg_rail = 0;
      sync_loss = 0; stat_clr = '0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // one strobe then one idle cycle carrying the opposite bit
   task automatic strobe(input int ch, input logic b);
      @(negedge clk);
      if (ch == 0) begin rai_vld = 1; rai_bit = b; end
      else begin mfa_vld = 1; mfa_bit = b; end
      @(posedge clk); #1;
   endtask

   task automatic idle(input int ch, input logic b);
      @(negedge clk);
      rai_vld = 0; mfa_vld = 0;
      if (ch == 0) rai_bit = b; else mfa_bit = b;
      @(posedge clk); #1;
   endtask

   task automatic rail(input logic p, input logic n);
      @(negedge clk);
      pos_rail = p; neg_rail = n;
      @(posedge clk); #1;
   endtask

   task automatic sweep(input int ch, input int p);
      logic exp, last, b;
      int run;
      exp = 0; run = 0; last = 0;
      do_reset();
      for (int k = 0; k < 6; k++) begin
         b = p[k];
         run = (k == 0 || b != last) ? 1 : run + 1;
         last = b;
         if (run >= 3) exp = b;
         strobe(ch, b);
         if (ch == 0) check(exp ? "R1" : (run >= 3 ? "R2" : "R3"), remote_alarm, exp);
         else begin
            check("R4", mf_alarm, exp);
            check("R4 other path", remote_alarm, 1'b0);
         end
         idle(ch, ~b);
         check("R11", ch == 0 ? remote_alarm : mf_alarm, exp);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog act=running exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      do_reset();
      #1;
      // R10
      check("R10", remote_alarm, 0); check("R10", mf_alarm, 0);
      check("R10", carrier_loss, 0); check("R10", stat[0], 0);
      check("R10", stat[1], 0); check("R10", stat[2], 0);

      for (int p = 0; p < 64; p++) sweep(0, p);
      for (int p = 0; p < 64; p++) sweep(1, p);

      // R5 / R6 zero runs of several lengths
      for (int len = RUN - 3; len <= RUN + 3; len++) begin
         do_reset();
         for (int i = 1; i <= len; i++) begin
            rail(0, 0);
            check("R5", carrier_loss, i >= RUN);
         end
         rail(len[0], ~len[0]);
         check("R6", carrier_loss, 0);
      end
      // R6 restart after a mark
      do_reset();
      for (int i = 0; i < RUN - 1; i++) rail(0, 0);
      rail(0, 1);
      for (int i = 0; i < RUN - 1; i++) rail(0, 0);
      check("R6 restart", carrier_loss, 0);
      rail(0, 0);
      check("R6 restart full", carrier_loss, 1);
      // R7 long outage
      do_reset();
      for (int i = 0; i < 300; i++) rail(0, 0);
      check("R7", carrier_loss, 1);
      rail(1, 0);
      check("R7 clear", carrier_loss, 0);

      // R8 sync status
      do_reset();
      @(negedge clk); sync_loss = 1;
      @(posedge clk); #1;
      @(negedge clk); sync_loss = 0;
      check("R8 sync set", stat[2], 1);
      repeat (5) @(posedge clk); #1;
      check("R8 sync hold", stat[2], 1);
      @(negedge clk); stat_clr = 3'b100;
      @(posedge clk); #1;
      @(negedge clk); stat_clr = 0;
      check("R8 sync clear", stat[2], 0);
      // R9 clear while live
      @(negedge clk); sync_loss = 1;
      @(posedge clk); #1;
      @(negedge clk); stat_clr = 3'b100;
      @(posedge clk); #1;
      @(negedge clk); stat_clr = 0; sync_loss = 0;
      check("R9 sync", stat[2], 1);

      // R8 / R9 remote status
      do_reset();
      for (int k = 0; k < 3; k++) strobe(0, 1);
      check("R8 remote live", remote_alarm, 1);
      idle(0, 1);
      check("R8 remote stat", stat[0], 1);
      @(negedge clk); stat_clr = 3'b001;
      @(posedge clk); #1;
      @(negedge clk); stat_clr = 0;
      check("R9 remote", stat[0], 1);
      for (int k = 0; k < 3; k++) strobe(0, 0);
      idle(0, 0);
      check("R8 remote hold", stat[0], 1);
      @(negedge clk); stat_clr = 3'b001;
      @(posedge clk); #1;
      @(negedge clk); stat_clr = 0;
      check("R8 remote clear", stat[0], 0);
      check("R8 mf untouched", stat[1], 0);

      // R8 multiframe status
      for (int k = 0; k < 3; k++) strobe(1, 1);
      idle(1, 1);
      check("R8 mf stat", stat[1], 1);
      check("R8 remote quiet", stat[0], 0);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule